// File: doc/BRIEF.md
# Supply Supervisor with Double Hiccup Restart

This block sequences the supply of an offline switching controller. It watches a set of already synchronized comparator flags on the bias supply, the feedback-open flag and an external shutdown request. From them it decides when the startup current source charges the supply, when the modulator may switch, and how the part recovers from faults.

After a fault the block does not retry at once. Switching stays off while the supply goes through two full discharge and recharge cycles, and only then does the block restart with a fresh soft-start pulse. An external shutdown request must first survive a persistence filter. Once accepted, it holds the part off. The supply then hiccups between its low and high thresholds until it collapses below the logic reset level.

Persistence windows are counted in clock cycles and set by parameters. At 50 MHz the defaults give 130 ms for the feedback-open timeout and 13 µs for the shutdown filter.

Top module: `supply_supervisor`

## Requirements
- R1: `src_hi` is high exactly when `src_en` is high and `vcc_gt_0v6` is high, in the same cycle with no register in the path.
- R2: Asynchronous reset (`rst_n` low) puts the block in the charging state, with `state_o` code 0, `src_en` high, and `run_en` and `ss_pulse` low.
- R3: In the charging state, the first clock edge that samples `vcc_gt_12v6` high moves the block to the running state (code 1). In that state `run_en` is high and `src_en` is low.
- R4: `ss_pulse` is high for exactly one cycle, the first cycle of every entry into the running state.
- R5: In the running state, an edge that samples `vcc_gt_9v1` low moves the block to hiccup-discharge (code 2), with `run_en` and `src_en` both low.
- R6: In the running state, `fb_open` sampled high on FB_LIMIT consecutive edges causes the same move to hiccup-discharge. Any edge that samples it low restarts the count.
- R7: Hiccup-discharge moves to hiccup-charge (code 3, `src_en` high) on an edge that samples `vcc_gt_5v8` low. Hiccup-charge moves on an edge that samples `vcc_gt_12v6` high. For the first HICCUPS-1 of these arrivals it returns to hiccup-discharge; on arrival number HICCUPS it enters the running state.
- R8: A fault after a restart starts the hiccup count again from zero.
- R9: `latch_req` sampled high on LATCH_LIMIT consecutive edges moves the block to latch-discharge (code 4). A shorter pulse has no effect.
- R10: Once latched, the block alternates between latch-discharge and latch-charge (code 5, `src_en` high), using the same 5.8 V and 12.6 V flags. It never raises `run_en`, and releasing `latch_req` changes nothing.
- R11: An edge that samples `vcc_gt_4v0` low sends the block to the charging state from any state. This clears the latch and the hiccup count, and it has the highest priority.
- R12: An accepted latch request overrides both the running state and the hiccup sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_gt_0v6 | input | 1 | Supply above 0.6 V |
| vcc_gt_4v0 | input | 1 | Supply above logic reset level (4.0 V) |
| vcc_gt_5v8 | input | 1 | Supply above hiccup low level (5.8 V) |
| vcc_gt_9v1 | input | 1 | Supply above undervoltage level (9.1 V) |
| vcc_gt_12v6 | input | 1 | Supply above start level (12.6 V) |
| fb_open | input | 1 | Feedback above 3 V (no regulation) |
| latch_req | input | 1 | Shutdown input above 8 V |
| src_en | output | 1 | Startup current source enable |
| src_hi | output | 1 | Startup current source high-current select |
| run_en | output | 1 | Modulator enable |
| ss_pulse | output | 1 | One-cycle soft-start restart |
| state_o | output | 3 | State code (0 charge, 1 run, 2 hiccup-discharge, 3 hiccup-charge, 4 latch-discharge, 5 latch-charge) |

## Verification
The properties assume that the supply flags are synchronized and that they hold on a consistent ladder: a higher threshold flag is never high while a lower one is low. They also assume the flags change only between clock edges. The bench drives the supply as a single millivolt value and derives every flag from that value. It changes the value only on the falling clock edge, so the ladder ordering always holds. The persistence counts are checked one edge short and one edge long by holding the request inputs for a counted number of edges.

// File: rtl/sup_pkg.sv
package sup_pkg;

   typedef enum logic [2:0] {
      SUP_CHARGE  = 3'd0,
      SUP_RUN     = 3'd1,
      SUP_HIC_DIS = 3'd2,
      SUP_HIC_CHG = 3'd3,
      SUP_LAT_DIS = 3'd4,
      SUP_LAT_CHG = 3'd5
   } sup_state_t;

   localparam int unsigned SUP_STATE_W = 3;

endpackage

// File: rtl/sup_persist_filter.sv
// Counts consecutive sampled edges with sig_in high; hit flags the LIMIT-th one.
module sup_persist_filter #(
   parameter int unsigned LIMIT = 650
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic hit
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("sup_persist_filter: LIMIT must be at least 1");
   end

   if (LIMIT < 2) begin : g_direct
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign hit = sig_in;
   end else begin : g_count
      localparam int unsigned CW = $clog2(LIMIT);
      localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (!sig_in)       cnt_q <= '0;
         else if (cnt_q != TOP)  cnt_q <= cnt_q + CW'(1);
      end

      assign hit = sig_in && (cnt_q == TOP);

      // R6 / R9: a hit needs the input high on the previous edge too
      assert_persist_R6_R9: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> $past(sig_in));
   end

endmodule

// File: rtl/sup_seq_fsm.sv
module sup_seq_fsm
   import sup_pkg::*;
#(
   parameter int unsigned HICCUPS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       v_rst,
   input  logic       v_low,
   input  logic       v_uvlo,
   input  logic       v_start,
   input  logic       fb_hit,
   input  logic       latch_hit,
   output sup_state_t state_q,
   output logic       ss_pulse
);

   localparam int unsigned CW = $clog2(HICCUPS + 1);
   localparam logic [CW-1:0] LAST = CW'(HICCUPS - 1);

   sup_state_t    nxt;
   logic [CW-1:0] hic_q, hic_n;
   logic          latched;

   assign latched = (state_q == SUP_LAT_DIS) || (state_q == SUP_LAT_CHG);

   always_comb begin
      nxt   = state_q;
      hic_n = hic_q;
      if (!v_rst) begin
         nxt   = SUP_CHARGE;
         hic_n = '0;
      end else if (latch_hit && !latched) begin
         nxt = SUP_LAT_DIS;
      end else begin
         unique case (state_q)
            SUP_CHARGE:  if (v_start) nxt = SUP_RUN;
            SUP_RUN:     if (!v_uvlo || fb_hit) begin
                            nxt   = SUP_HIC_DIS;
                            hic_n = '0;
                         end
            SUP_HIC_DIS: if (!v_low) nxt = SUP_HIC_CHG;
            SUP_HIC_CHG: if (v_start) begin
                            if (hic_q == LAST) begin
                               nxt   = SUP_RUN;
                               hic_n = '0;
                            end else begin
                               nxt   = SUP_HIC_DIS;
                               hic_n = hic_q + CW'(1);
                            end
                         end
            SUP_LAT_DIS: if (!v_low) nxt = SUP_LAT_CHG;
            SUP_LAT_CHG: if (v_start) nxt = SUP_LAT_DIS;
            default:     nxt = SUP_CHARGE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SUP_CHARGE;
         hic_q    <= '0;
         ss_pulse <= 1'b0;
      end else begin
         state_q  <= nxt;
         hic_q    <= hic_n;
         ss_pulse <= (nxt == SUP_RUN) && (state_q != SUP_RUN);
      end
   end

   // R3: entry into run only after the start threshold was seen
   assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == SUP_RUN) |-> $past(v_start));

   // R4: every run entry carries the soft-start pulse, and only in run
   assert_ss_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == SUP_RUN) |-> ss_pulse);
   assert_ss_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ss_pulse |-> (state_q == SUP_RUN));

   // R5: undervoltage while running leaves run next cycle
   assert_uvlo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SUP_RUN) && !v_uvlo |=> (state_q != SUP_RUN));

   // R10: latched states persist while the supply stays above reset level
   assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      latched && v_rst |=> (state_q == SUP_LAT_DIS) || (state_q == SUP_LAT_CHG));

   // R11: logic reset level wins over everything
   assert_logic_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !v_rst |=> (state_q == SUP_CHARGE));

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
   import sup_pkg::*;
#(
   parameter int unsigned FB_LIMIT    = 6_500_000,
   parameter int unsigned LATCH_LIMIT = 650,
   parameter int unsigned HICCUPS     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vcc_gt_0v6,
   input  logic       vcc_gt_4v0,
   input  logic       vcc_gt_5v8,
   input  logic       vcc_gt_9v1,
   input  logic       vcc_gt_12v6,
   input  logic       fb_open,
   input  logic       latch_req,
   output logic       src_en,
   output logic       src_hi,
   output logic       run_en,
   output logic       ss_pulse,
   output logic [2:0] state_o
);

   if (HICCUPS < 1) begin : g_bad_hiccups
      $error("supply_supervisor: HICCUPS must be at least 1");
   end

   sup_state_t st;
   logic       fb_hit, latch_hit;

   sup_persist_filter #(.LIMIT(FB_LIMIT)) u_fb_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (fb_open && (st == SUP_RUN)),
      .hit    (fb_hit)
   );

   sup_persist_filter #(.LIMIT(LATCH_LIMIT)) u_latch_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (latch_req),
      .hit    (latch_hit)
   );

   sup_seq_fsm #(.HICCUPS(HICCUPS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .v_rst     (vcc_gt_4v0),
      .v_low     (vcc_gt_5v8),
      .v_uvlo    (vcc_gt_9v1),
      .v_start   (vcc_gt_12v6),
      .fb_hit    (fb_hit),
      .latch_hit (latch_hit),
      .state_q   (st),
      .ss_pulse  (ss_pulse)
   );

   assign src_en  = (st == SUP_CHARGE) || (st == SUP_HIC_CHG) || (st == SUP_LAT_CHG);
   assign src_hi  = src_en && vcc_gt_0v6;
   assign run_en  = (st == SUP_RUN);
   assign state_o = st;

   // R10: a latched part never switches
   assert_latched_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd4) && vcc_gt_4v0 |=> !run_en);

endmodule

// File: tb/supply_supervisor_bench.sv
`timescale 1ns/1ps
module supply_supervisor_bench;

   localparam int FB_L  = 40;
   localparam int LAT_L = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic v06 = 0, v40 = 0, v58 = 0, v91 = 0, v126 = 0;
   logic fb_open = 0, latch_req = 0;
   logic src_en, src_hi, run_en, ss_pulse;
   logic [2:0] state_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   supply_supervisor #(.FB_LIMIT(FB_L), .LATCH_LIMIT(LAT_L), .HICCUPS(2)) u_supply_supervisor (
      .clk(clk), .rst_n(rst_n),
      .vcc_gt_0v6(v06), .vcc_gt_4v0(v40), .vcc_gt_5v8(v58),
      .vcc_gt_9v1(v91), .vcc_gt_12v6(v126),
      .fb_open(fb_open), .latch_req(latch_req),
      .src_en(src_en), .src_hi(src_hi), .run_en(run_en),
      .ss_pulse(ss_pulse), .state_o(state_o)
   );

   task automatic set_vcc(input int mv);
      v06  = (mv > 600);
      v40  = (mv > 4000);
      v58  = (mv > 5800);
      v91  = (mv > 9100);
      v126 = (mv > 12600);
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // hiccup-charge after discharge, then arrival at the start level
   task automatic hic_step(input string tag, input int exp_after);
      set_vcc(5000); tick(1);
      chk({tag, " charge state"}, state_o, 3);
      chk({tag, " charge src_en"}, src_en, 1);
      set_vcc(13000); tick(1);
      chk({tag, " arrival state"}, state_o, exp_after);
   endtask

   task automatic t_reset;
      tick(2);
      chk("R2 state", state_o, 0);
      chk("R2 src_en", src_en, 1);
      chk("R2 run_en", run_en, 0);
      chk("R2 ss_pulse", ss_pulse, 0);
      chk("R1 low supply src_hi", src_hi, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_boot;
      set_vcc(300); tick(1);
      chk("R1 below inhibit", src_hi, 0);
      set_vcc(2000); #1;
      chk("R1 above inhibit same cycle", src_hi, 1);
      set_vcc(11000); tick(3);
      chk("R3 below start", state_o, 0);
      set_vcc(13000); tick(1);
      chk("R3 state run", state_o, 1);
      chk("R3 run_en", run_en, 1);
      chk("R3 src_en off", src_en, 0);
      chk("R1 src_hi off", src_hi, 0);
      chk("R4 pulse", ss_pulse, 1);
      tick(1);
      chk("R4 one cycle", ss_pulse, 0);
      set_vcc(12000);
   endtask

   task automatic t_uvlo;
      set_vcc(8000); tick(1);
      chk("R5 state", state_o, 2);
      chk("R5 run_en", run_en, 0);
      chk("R5 src_en", src_en, 0);
      hic_step("R7 first", 2);
      chk("R7 no run after first", run_en, 0);
      hic_step("R7 second", 1);
      chk("R4 restart pulse", ss_pulse, 1);
      set_vcc(12000);
   endtask

   task automatic t_fb_timer;
      fb_open = 1; tick(FB_L - 5);
      fb_open = 0; tick(1);
      chk("R6 short open", state_o, 1);
      fb_open = 1; tick(FB_L - 1);
      chk("R6 one short", state_o, 1);
      tick(1);
      chk("R6 timeout", state_o, 2);
      fb_open = 0;
      hic_step("R6 h1", 2);
      hic_step("R6 h2", 1);
      set_vcc(12000);
   endtask

   task automatic t_repeat;
      fb_open = 1; tick(FB_L);
      chk("R8 first fault", state_o, 2);
      hic_step("R8 h1", 2);
      hic_step("R8 h2", 1);
      set_vcc(12000);
      tick(FB_L - 1);
      chk("R8 still run", state_o, 1);
      tick(1);
      chk("R8 refault", state_o, 2);
      fb_open = 0;
      hic_step("R8 count restarted", 2);
      hic_step("R8 restart", 1);
      set_vcc(12000);
   endtask

   task automatic t_reset_clears;
      set_vcc(8000); tick(1);
      chk("R11 fault", state_o, 2);
      hic_step("R11 h1", 2);
      set_vcc(3000); tick(1);
      chk("R11 to charge", state_o, 0);
      chk("R11 src_en", src_en, 1);
      set_vcc(13000); tick(1);
      chk("R11 run", state_o, 1);
      set_vcc(8000); tick(1);
      hic_step("R11 count cleared", 2);
      hic_step("R11 restart", 1);
      set_vcc(12000);
   endtask

   task automatic t_latch;
      latch_req = 1; tick(LAT_L - 1);
      latch_req = 0; tick(1);
      chk("R9 short request", state_o, 1);
      latch_req = 1; tick(LAT_L - 1);
      chk("R9 one short", state_o, 1);
      tick(1);
      chk("R9 latched", state_o, 4);
      chk("R9 run_en", run_en, 0);
      latch_req = 0;
      for (int i = 0; i < 3; i++) begin
         set_vcc(5000); tick(1);
         chk("R10 latch charge", state_o, 5);
         chk("R10 src_en", src_en, 1);
         set_vcc(13000); tick(1);
         chk("R10 latch discharge", state_o, 4);
         chk("R10 run_en", run_en, 0);
      end
      set_vcc(3000); tick(1);
      chk("R11 latch cleared", state_o, 0);
      set_vcc(13000); tick(1);
      chk("R11 run after clear", state_o, 1);
      set_vcc(12000);
   endtask

   task automatic t_priority;
      set_vcc(8000); tick(1);
      chk("R12 in hiccup", state_o, 2);
      latch_req = 1; tick(LAT_L);
      chk("R12 latch over hiccup", state_o, 4);
      latch_req = 0;
      set_vcc(3000); tick(1);
      chk("R12 cleared", state_o, 0);
   endtask

   initial begin
      set_vcc(0);
      @(negedge clk);
      t_reset();
      t_boot();
      t_uvlo();
      t_fb_timer();
      t_repeat();
      t_reset_clears();
      t_latch();
      t_priority();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule